// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block sits above a management-bus (MDIO) read engine and finds an attached Ethernet PHY without prior knowledge of its address. After a start pulse it issues reads of identifier register 3 to management addresses 0, 1, 2 and so on up to 31. The first address that answers with anything other than 0xFFFF is taken as the PHY. The scanner then reads identifier register 2 at that same address and joins the two halves into a 32-bit identifier.

When a full sweep of all 32 addresses finds nothing, the scanner waits 10 ms and sweeps again. The wait is set by a clock-frequency parameter. It gives up after a fixed number of sweeps and reports that no PHY was found. Each register read is a simple request/response exchange: the request is held with a stable address and register number until the read engine returns a one-cycle response strobe carrying the 16-bit data.

Top module: `phy_scan`

## Requirements
- R1: After reset, busy, done, found, not_found and mdio_req are all 0.
- R2: In the cycle after a start pulse that arrives while idle, busy is 1 and a request is presented for address 0, register 3.
- R3: Register-3 reads go to addresses in strictly ascending order from 0. Each next read is requested in the cycle right after the response to the previous one. A response of 0xFFFF means no PHY is at that address.
- R4: The first register-3 response that is not 0xFFFF ends the sweep. Exactly one further read then follows, of register 2 at the same address, and no other address is probed.
- R5: After a hit, found=1, busy=0, phy_addr holds the hit address and phy_id is {register-2 data, register-3 data}, with register 2 in bits 31:16.
- R6: Between sweeps, no request is presented for exactly CLK_HZ/100 cycles (10 ms), counted from the response to address 31 until the request to address 0 of the next sweep.
- R7: At most MAX_PASSES sweeps are made (default 11). If all of them fail, not_found=1, found=0, phy_addr=0 and busy=0, after exactly 32*MAX_PASSES reads.
- R8: A PHY that starts to answer only in a later sweep is found in that sweep, with the same results as R5.
- R9: phy_model equals phy_id bits 31:4, which drops the 4-bit revision field.
- R10: A start pulse while busy is ignored. The sweep order and the final result are the same as without it.
- R11: done is a single-cycle pulse, raised in the same cycle that found or not_found is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (one-cycle pulse) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | A PHY was located |
| not_found | output | 1 | All sweeps failed |
| phy_addr | output | 5 | Address of the located PHY, 0 otherwise |
| phy_id | output | 32 | Identifier {reg2, reg3} |
| phy_model | output | 28 | Identifier without revision bits |
| mdio_req | output | 1 | Read request to the management engine |
| mdio_phy | output | 5 | Address of the requested read |
| mdio_reg | output | 5 | Register number of the requested read |
| mdio_rsp_valid | input | 1 | Read data strobe |
| mdio_rsp_data | input | 16 | Read data |

## Verification
Within a sweep, the next request is due in the cycle right after each response strobe. Across a sweep boundary it is due exactly CLK_HZ/100 cycles after the strobe for address 31. The bench's responder stamps the cycle of every strobe and compares it with the cycle in which the next request appears. done, found and the identifier are due in the cycle after the final response, so they are sampled on the falling edge where done is first seen high. done must be low again on the next falling edge.

// File: rtl/phy_scan.sv
module phy_scan #(
  parameter int          CLK_HZ     = 50_000_000,
  parameter int          MAX_PASSES = 11,
  parameter logic [4:0]  REG_ID1    = 5'd2,
  parameter logic [4:0]  REG_ID2    = 5'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        found,
  output logic        not_found,
  output logic [4:0]  phy_addr,
  output logic [31:0] phy_id,
  output logic [27:0] phy_model,
  output logic        mdio_req,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  input  logic        mdio_rsp_valid,
  input  logic [15:0] mdio_rsp_data
);

  localparam int WAIT_CYC = (CLK_HZ / 100 > 0) ? CLK_HZ / 100 : 1;
  localparam int TW       = $clog2(WAIT_CYC + 1);
  localparam int PW       = $clog2(MAX_PASSES + 1);

  typedef enum logic [1:0] {S_IDLE, S_ID2, S_ID1, S_WAIT} st_t;

  st_t          st;
  logic [4:0]   addr;
  logic [PW-1:0] pass;
  logic [TW-1:0] tmr;
  logic [15:0]  id_lo;

  assign busy      = (st != S_IDLE);
  assign mdio_req  = (st == S_ID2) || (st == S_ID1);
  assign mdio_phy  = addr;
  assign mdio_reg  = (st == S_ID1) ? REG_ID1 : REG_ID2;
  assign phy_model = phy_id[31:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr      <= '0;
      pass      <= '0;
      tmr       <= '0;
      id_lo     <= '0;
      done      <= 1'b0;
      found     <= 1'b0;
      not_found <= 1'b0;
      phy_addr  <= '0;
      phy_id    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st        <= S_ID2;
          addr      <= '0;
          pass      <= PW'(1);
          found     <= 1'b0;
          not_found <= 1'b0;
          phy_addr  <= '0;
          phy_id    <= '0;
        end
        S_ID2: if (mdio_rsp_valid) begin
          if (mdio_rsp_data != 16'hFFFF) begin
            id_lo <= mdio_rsp_data;
            st    <= S_ID1;
          end else if (addr == 5'd31) begin
            if (pass == PW'(MAX_PASSES)) begin
              not_found <= 1'b1;
              done      <= 1'b1;
              st        <= S_IDLE;
            end else begin
              tmr <= '0;
              st  <= S_WAIT;
            end
          end else begin
            addr <= addr + 5'd1;
          end
        end
        S_ID1: if (mdio_rsp_valid) begin
          phy_id   <= {mdio_rsp_data, id_lo};
          phy_addr <= addr;
          found    <= 1'b1;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        S_WAIT: begin
          if (tmr == TW'(WAIT_CYC - 1)) begin
            addr <= '0;
            pass <= pass + PW'(1);
            st   <= S_ID2;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_first_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mdio_req && mdio_phy == 5'd0 && mdio_reg == REG_ID2));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_rsp_valid) |=> (mdio_req && $stable(mdio_phy) && $stable(mdio_reg)));

  p_found_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (!busy && !not_found));

  p_pass_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass <= PW'(MAX_PASSES));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (found != not_found) && !busy);

endmodule

// File: tb/sim_phy_scan.sv
module sim_phy_scan;
  localparam int HZ = 100_000;
  localparam int W  = HZ / 100;
  localparam int NP = 11;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, found, not_found, mdio_req, rsp_valid = 0;
  logic [4:0] phy_addr, mdio_phy, mdio_reg;
  logic [31:0] phy_id;
  logic [27:0] phy_model;
  logic [15:0] rsp_data = 0;

  int total = 0, bad = 0;
  int cyc = 0, last_rsp = 0, cnt = 0;
  int m_addr = -1, m_pass = 1;
  logic [15:0] m_id1 = 0, m_id2 = 0, rdata = 0;
  int exp_a = 0, pass_n = 1, hit_a = 0, reads_n = 0, seq_err = 0;
  bit first_req = 1, gap_due = 0, want_id1 = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_scan #(.CLK_HZ(HZ), .MAX_PASSES(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .found(found), .not_found(not_found), .phy_addr(phy_addr),
    .phy_id(phy_id), .phy_model(phy_model), .mdio_req(mdio_req),
    .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_rsp_valid(rsp_valid), .mdio_rsp_data(rsp_data));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // responder: two-cycle read latency, also checks order and spacing of requests
  initial forever begin
    @(negedge clk);
    rsp_valid = 0;
    if (mdio_req) begin
      if (cnt == 0) begin
        reads_n++;
        if (!first_req && (cyc - last_rsp) != (gap_due ? W : 0)) seq_err++;
        first_req = 0;
        gap_due = 0;
        if (want_id1) begin
          if (mdio_reg != 5'd2 || int'(mdio_phy) != hit_a) seq_err++;
          rdata = m_id1;
          want_id1 = 0;
        end else begin
          if (mdio_reg != 5'd3 || int'(mdio_phy) != exp_a) seq_err++;
          if (m_addr == int'(mdio_phy) && pass_n >= m_pass) begin
            rdata = m_id2;
            want_id1 = 1;
            hit_a = int'(mdio_phy);
          end else begin
            rdata = 16'hFFFF;
            if (exp_a == 31) begin exp_a = 0; pass_n++; gap_due = 1; end
            else exp_a++;
          end
        end
      end
      cnt++;
      if (cnt == 2) begin
        rsp_valid = 1;
        rsp_data = rdata;
        cnt = 0;
        last_rsp = cyc + 1;
      end
    end
  end

  task automatic run_scan(input int a, input int p, input logic [15:0] id1, input logic [15:0] id2,
                          input int mid_start, input string req);
    int t;
    m_addr = a; m_pass = p; m_id1 = id1; m_id2 = id2;
    exp_a = 0; pass_n = 1; reads_n = 0; seq_err = 0;
    first_req = 1; gap_due = 0; want_id1 = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    chk(mdio_req === 1'b1 && mdio_phy == 0 && mdio_reg == 3, "R2 first request", {mdio_req, mdio_phy, mdio_reg}, {1'b1, 5'd0, 5'd3});
    t = 0;
    while (done !== 1'b1 && t < 40000) begin
      @(negedge clk);
      t++;
      if (t == mid_start) start = 1;
      else start = 0;
    end
    start = 0;
    chk(done === 1'b1, {req, " R11 done seen"}, done, 1);
    chk(seq_err == 0, {req, " R3 R4 R6 request order and spacing"}, seq_err, 0);
    if (a >= 0) begin
      chk(found === 1 && not_found === 0, {req, " R5 found"}, {found, not_found}, 2'b10);
      chk(phy_addr == 5'(a), {req, " R5 address"}, phy_addr, a);
      chk(phy_id == {id1, id2}, {req, " R5 id"}, phy_id, {id1, id2});
      chk(phy_model == {id1, id2[15:4]}, {req, " R9 model"}, phy_model, {id1, id2[15:4]});
      chk(reads_n == (p - 1) * 32 + a + 2, {req, " R4 read count"}, reads_n, (p - 1) * 32 + a + 2);
    end else begin
      chk(found === 0 && not_found === 1 && phy_addr == 0, {req, " R7 not found"}, {found, not_found, phy_addr}, {2'b01, 5'd0});
      chk(reads_n == 32 * NP, {req, " R7 read count"}, reads_n, 32 * NP);
    end
    chk(busy === 0, {req, " R5 R7 idle at end"}, busy, 0);
    @(negedge clk);
    chk(done === 0, {req, " R11 done one cycle"}, done, 0);
    chk(mdio_req === 0, {req, " R4 no further reads"}, mdio_req, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && found === 0 && not_found === 0 && mdio_req === 0,
        "R1 reset state", {busy, done, found, not_found, mdio_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && mdio_req === 0, "R1 idle after reset release", {busy, mdio_req}, 0);
  endtask

  initial begin
    t_reset();
    run_scan(0, 1, 16'h0022, 16'h1561, 0, "addr0");
    run_scan(31, 1, 16'h0181, 16'hB88A, 0, "R3 addr31");
    run_scan(7, 3, 16'h0013, 16'h78E5, 0, "R6 R8 late");
    run_scan(12, 1, 16'h2000, 16'h5C9F, 0, "R9 rev");
    run_scan(20, 1, 16'h0007, 16'hC0F1, 15, "R10 restart");
    run_scan(-1, 1, 16'h0, 16'h0, 0, "R7 none");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule